// File: doc/BRIEF.md
# Bank-Mapped Port Expander Register File

This block holds the register file behind a serial-bus port expander that drives two 8-bit ports, A and B. Each port owns eleven byte registers. One configuration register is shared by both ports. A protocol front end, which sits outside this block, turns bus traffic into a stream of byte commands. A command can load the address pointer, write the register that the pointer selects, or read it. Read data comes back on a separate response stream. The full contents of both ports are always visible as flat output vectors, and the pin logic uses them.

The address map has two layouts, and a bit in the configuration register picks between them. In the interleaved layout, each A/B register pair sits at a pair of neighbouring addresses. In the segregated layout, port A has one block of addresses and port B has a block starting at 10h. The pointer can step forward after every data byte, so a single transfer can sweep through consecutive addresses. It can also stay put, so that one register is polled or rewritten repeatedly. A change of layout takes effect from the next byte onward. The pointer is not corrected, so a sweep can run into unmapped addresses.

Both streams use valid/ready. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. A response is consumed in a cycle where `rsp_valid` and `rsp_ready` are both high. While a response is stalled, the command stream is held off, so at most one response is ever outstanding.

Top module: `rfx_regfile`

## Requirements
- R1: After reset every register reads 00h, except the port direction register (index 0 of each port), which is FFh. The configuration register is 00h, which selects the interleaved layout with pointer stepping enabled.
- R2: When configuration bit 7 (the bank bit) is 0, addresses 00h–15h map as index = address/2. An even address selects port A and an odd address selects port B.
- R3: When the bank bit is 1, addresses 00h–0Ah map to port A index 0–10. Addresses 10h–1Ah map to port B index 0–10.
- R4: Index 5 is the one shared configuration register. It is reached at 0Ah and 0Bh in the interleaved layout, and at 05h and 15h in the segregated layout. Both port output vectors show its value at index 5.
- R5: A read from an unmapped address returns 00h. A write to an unmapped address changes no register.
- R6: A command with `cmd_op` = 00 loads the pointer from `cmd_data`. The next data command uses that address.
- R7: Opcode 01 writes `cmd_data` and opcode 10 reads. After either one, the pointer steps by one, modulo 256, if configuration bit 5 (the hold bit) was 0 before that byte. If the hold bit was 1, the pointer stays where it is.
- R8: A new bank setting applies to decoding from the byte after the one that wrote it, with no pointer correction. With stepping enabled, writing 80h at 0Ah leaves the pointer at 0Bh, and 0Bh is unmapped in the segregated layout.
- R9: A read is answered on the response stream by the register value at the moment the read is taken. The response stays valid, with its data unchanged, until it is accepted.
- R10: `cmd_ready` is low whenever `rsp_valid` is high and `rsp_ready` is low.
- R11: Opcode 11 is accepted and has no effect on the pointer or on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command available |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 2 | 00 load pointer, 01 write, 10 read, 11 no operation |
| cmd_data | input | 8 | Address byte or write data |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte |
| port_a_regs | output | 88 | Port A registers, index i in bits 8i+7:8i |
| port_b_regs | output | 88 | Port B registers, index i in bits 8i+7:8i |

## Verification
The assertions assume that the front end follows the valid/ready rules: it keeps `cmd_op` and `cmd_data` steady while `cmd_valid` waits for `cmd_ready`, and it leaves `rsp_ready` free to stall for any number of cycles. The bench driver therefore changes a command only after that command has been accepted. The consumer side changes `rsp_ready` only on the falling clock edge, following fixed stall patterns and one forced long stall. Each expected byte in the scoreboard comes from a separate address model of both layouts and the hold bit. The test sequence covers a layout switch in the middle of a sweep and a pointer wrap from FFh.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } rfx_op_e;
endpackage

// File: rtl/rfx_decode.sv
module rfx_decode #(
  parameter int DW       = 8,
  parameter int NREG     = 11,
  parameter int SEG_BASE = 16,
  localparam int IW      = $clog2(NREG)
) (
  input  logic [DW-1:0] addr,
  input  logic          bank,
  output logic          hit,
  output logic          port_b,
  output logic [IW-1:0] idx
);
  localparam logic [DW-1:0] A_LIMIT  = DW'(NREG);
  localparam logic [DW-1:0] B_FIRST  = DW'(SEG_BASE);
  localparam logic [DW-1:0] B_LIMIT  = DW'(SEG_BASE + NREG);
  localparam logic [DW-1:0] IL_LIMIT = DW'(2 * NREG);

  logic [DW-1:0] seg_off;
  logic [DW-1:0] pair_no;

  assign seg_off = addr - B_FIRST;
  assign pair_no = addr >> 1;

  always_comb begin
    hit    = 1'b0;
    port_b = 1'b0;
    idx    = '0;
    if (bank) begin
      if (addr < A_LIMIT) begin
        hit = 1'b1;
        idx = addr[IW-1:0];
      end else if (addr >= B_FIRST && addr < B_LIMIT) begin
        hit    = 1'b1;
        port_b = 1'b1;
        idx    = seg_off[IW-1:0];
      end
    end else if (addr < IL_LIMIT) begin
      hit    = 1'b1;
      port_b = addr[0];
      idx    = pair_no[IW-1:0];
    end
  end
endmodule

// File: rtl/rfx_ptr.sv
module rfx_ptr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  output logic [DW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/rfx_store.sv
module rfx_store #(
  parameter int            DW      = 8,
  parameter int            NREG    = 11,
  parameter int            CFG_IDX = 5,
  parameter int            DIR_IDX = 0,
  parameter logic [DW-1:0] DIR_RST = '1,
  localparam int           IW      = $clog2(NREG),
  localparam int           VW      = NREG * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel_b,
  input  logic [IW-1:0] sel_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cfg,
  output logic [VW-1:0] vec_a,
  output logic [VW-1:0] vec_b
);
  logic [2*VW-1:0] all_q;
  logic            cfg_hit;

  assign cfg_hit = (sel_idx == IW'(CFG_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg <= '0;
    else if (wr_en && cfg_hit) cfg <= wr_data;
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == CFG_IDX) begin : g_shared
        assign all_q[(p*NREG+i)*DW +: DW] = cfg;
      end else begin : g_own
        localparam logic [DW-1:0] RV = (i == DIR_IDX) ? DIR_RST : '0;
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RV;
          else if (wr_en && (sel_b == 1'(p)) && (sel_idx == IW'(i))) q <= wr_data;
        end
        assign all_q[(p*NREG+i)*DW +: DW] = q;
      end
    end
  end

  assign vec_a = all_q[VW-1:0];
  assign vec_b = all_q[2*VW-1:VW];

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (sel_idx == IW'(k)) begin
        rd_data = sel_b ? vec_b[k*DW +: DW] : vec_a[k*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile #(
  parameter int DW       = 8,
  parameter int NREG     = 11,
  parameter int CFG_IDX  = 5,
  parameter int DIR_IDX  = 0,
  parameter int SEG_BASE = 16,
  parameter int BANK_BIT = 7,
  parameter int HOLD_BIT = 5,
  localparam int IW      = $clog2(NREG),
  localparam int VW      = NREG * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [VW-1:0] port_a_regs,
  output logic [VW-1:0] port_b_regs
);
  import rfx_pkg::*;

  rfx_op_e       op;
  logic          fire, is_start, is_wr, is_rd;
  logic [DW-1:0] ptr_q;
  logic [DW-1:0] cfg_q;
  logic          bank, hold;
  logic          sel_hit, sel_b;
  logic [IW-1:0] sel_idx;
  logic [DW-1:0] rd_val;

  assign op        = rfx_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign is_start  = fire && (op == OP_START);
  assign is_wr     = fire && (op == OP_WRITE);
  assign is_rd     = fire && (op == OP_READ);
  assign bank      = cfg_q[BANK_BIT];
  assign hold      = cfg_q[HOLD_BIT];

  rfx_ptr #(.DW(DW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (is_start),
    .load_val (cmd_data),
    .step     ((is_wr || is_rd) && !hold),
    .ptr      (ptr_q)
  );

  rfx_decode #(.DW(DW), .NREG(NREG), .SEG_BASE(SEG_BASE)) u_dec (
    .addr   (ptr_q),
    .bank   (bank),
    .hit    (sel_hit),
    .port_b (sel_b),
    .idx    (sel_idx)
  );

  rfx_store #(
    .DW(DW), .NREG(NREG), .CFG_IDX(CFG_IDX), .DIR_IDX(DIR_IDX), .DIR_RST('1)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (is_wr && sel_hit),
    .sel_b   (sel_b),
    .sel_idx (sel_idx),
    .wr_data (cmd_data),
    .rd_data (rd_val),
    .cfg     (cfg_q),
    .vec_a   (port_a_regs),
    .vec_b   (port_b_regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (is_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel_hit ? rd_val : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rfx_regfile_chk.sv
module rfx_regfile_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [DW-1:0] cmd_data,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [DW-1:0] ptr,
  input logic          hit,
  input logic          hold
);
  logic fire_c, data_c;
  assign fire_c = cmd_valid && cmd_ready;
  assign data_c = fire_c && (cmd_op == 2'b01 || cmd_op == 2'b10);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_cmd_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready);

  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c && cmd_op == 2'b00 |=> ptr == $past(cmd_data));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_c && !hold |=> ptr == DW'($past(ptr) + 1'b1));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_c && hold |=> $stable(ptr));

  assert_ptr_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_c || cmd_op == 2'b11 |=> $stable(ptr));

  assert_unmapped_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c && cmd_op == 2'b10 && !hit |=> rsp_valid && rsp_data == '0);
endmodule

bind rfx_regfile rfx_regfile_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ptr       (ptr_q),
  .hit       (sel_hit),
  .hold      (hold)
);

// File: tb/rfx_regfile_test.sv
`timescale 1ns/1ps
module rfx_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b11;
  logic [7:0]  cmd_data = 8'h00;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [87:0] port_a_regs, port_b_regs;

  always #2 clk = ~clk;

  rfx_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .port_a_regs(port_a_regs), .port_b_regs(port_b_regs)
  );

  int nvec = 0;
  int nbad = 0;
  logic [7:0] m_reg [0:1][0:10];
  logic [7:0] m_cfg = 8'h00;
  logic [7:0] m_ptr = 8'h00;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         bp_on = 1'b0;
  bit         force_stall = 1'b0;
  int         cyc = 0;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // address model from R2/R3
  task automatic m_dec(input logic [7:0] a, output bit hit, output int pb, output int idx);
    hit = 0; pb = 0; idx = 0;
    if (m_cfg[7]) begin
      if (a <= 8'h0A) begin hit = 1; idx = int'(a); end
      else if (a >= 8'h10 && a <= 8'h1A) begin hit = 1; pb = 1; idx = int'(a) - 16; end
    end else if (a <= 8'h15) begin
      hit = 1; pb = int'(a[0]); idx = int'(a) / 2;
    end
  endtask

  function automatic logic [7:0] m_val(input int pb, input int idx);
    return (idx == 5) ? m_cfg : m_reg[pb][idx];
  endfunction

  // driver: issues one command, updates the model at acceptance
  task automatic send(input logic [1:0] op, input logic [7:0] d, input string tag);
    bit hit; int pb; int idx; bit old_hold;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    old_hold = m_cfg[5];
    m_dec(m_ptr, hit, pb, idx);
    case (op)
      2'b00: m_ptr = d;
      2'b01: begin
        if (hit) begin
          if (idx == 5) m_cfg = d; else m_reg[pb][idx] = d;
        end
        if (!old_hold) m_ptr = m_ptr + 8'd1;
      end
      2'b10: begin
        exp_q.push_back(hit ? m_val(pb, idx) : 8'h00);
        tag_q.push_back(tag);
        if (!old_hold) m_ptr = m_ptr + 8'd1;
      end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_ports(input string req);
    #1;
    for (int i = 0; i < 11; i++) begin
      check8(req, port_a_regs[i*8 +: 8], m_val(0, i));
      check8(req, port_b_regs[i*8 +: 8], m_val(1, i));
    end
  endtask

  // monitor: drives rsp_ready, pops and compares responses
  always @(negedge clk) begin
    string t; logic [7:0] e;
    cyc++;
    rsp_ready = force_stall ? 1'b0 : (bp_on ? (cyc % 3 != 0) : 1'b1);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        nvec++; nbad++;
        $display("FAIL R9: got %h expected no response", rsp_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check8(t, rsp_data, e);
      end
    end
  end

  initial begin
    #(4 * 150000);
    nbad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 11; i++) m_reg[p][i] = (i == 0) ? 8'hFF : 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_ports("R1 reset");

    // R2 interleaved sequential writes with stepping (R6, R7)
    send(2'b00, 8'h00, "R6");
    for (int k = 0; k < 8; k++) send(2'b01, 8'h30 + 8'(k), "R2");
    check_ports("R2 interleaved writes");
    bp_on = 1'b1;
    send(2'b00, 8'h00, "R6");
    for (int k = 0; k < 8; k++) send(2'b10, 8'h00, "R2 readback");
    send(2'b00, 8'h14, "R6");
    send(2'b01, 8'hA4, "R2");
    send(2'b01, 8'hB5, "R2");
    send(2'b01, 8'hEE, "R5");
    send(2'b00, 8'h14, "R6");
    for (int k = 0; k < 3; k++) send(2'b10, 8'h00, "R5 unmapped read");
    check_ports("R5 unmapped write ignored");

    // R4 config mirror in interleaved layout
    send(2'b00, 8'h0B, "R6");
    send(2'b10, 8'h00, "R4 cfg at 0Bh");

    // R7 hold bit
    send(2'b00, 8'h0A, "R6");
    send(2'b01, 8'h20, "R7");
    send(2'b00, 8'h02, "R6");
    send(2'b01, 8'h11, "R7");
    send(2'b01, 8'h44, "R7");
    for (int k = 0; k < 3; k++) send(2'b10, 8'h00, "R7 hold read");
    check_ports("R7 hold writes");
    send(2'b00, 8'h0A, "R6");
    send(2'b01, 8'h00, "R7");

    // R11 no-op opcode
    send(2'b00, 8'h04, "R6");
    send(2'b11, 8'h99, "R11");
    send(2'b10, 8'h00, "R11 pointer unchanged");
    check_ports("R11 no register change");

    // R9 / R10 forced stall
    force_stall = 1'b1;
    send(2'b00, 8'h01, "R6");
    send(2'b10, 8'h00, "R9 stalled read");
    #1;
    nvec++;
    if (!(rsp_valid && !cmd_ready)) begin
      nbad++;
      $display("FAIL R10: got valid=%0b ready=%0b expected valid=1 ready=0", rsp_valid, cmd_ready);
    end
    held = rsp_data;
    repeat (3) @(negedge clk);
    #1;
    check8("R9 data held", rsp_data, held);
    force_stall = 1'b0;
    @(negedge clk);

    // R8 bank switch mid-transfer
    send(2'b00, 8'h0A, "R6");
    send(2'b01, 8'h80, "R8");
    send(2'b01, 8'h55, "R8");
    send(2'b10, 8'h00, "R8 0Ch unmapped after switch");
    check_ports("R8 no correction");

    // R3 segregated layout
    send(2'b00, 8'h10, "R6");
    for (int k = 0; k < 5; k++) send(2'b01, 8'hC0 + 8'(k), "R3");
    send(2'b00, 8'h16, "R6");
    send(2'b01, 8'hD6, "R3");
    send(2'b01, 8'hD7, "R3");
    send(2'b01, 8'hD8, "R3");
    send(2'b01, 8'hD9, "R3");
    send(2'b01, 8'hDA, "R3");
    send(2'b01, 8'hDB, "R5");
    check_ports("R3 segregated writes");
    send(2'b00, 8'h00, "R6");
    for (int k = 0; k < 11; k++) send(2'b10, 8'h00, "R3 port A read");
    send(2'b00, 8'h05, "R6");
    send(2'b10, 8'h00, "R4 cfg at 05h");
    send(2'b00, 8'h15, "R6");
    send(2'b10, 8'h00, "R4 cfg at 15h");
    send(2'b00, 8'h2A, "R6");
    send(2'b10, 8'h00, "R5 unmapped 2Ah");

    // R7 wrap from FFh
    send(2'b00, 8'hFF, "R6");
    send(2'b01, 8'h5A, "R7");
    send(2'b01, 8'h3C, "R7");
    check_ports("R7 wrap");

    // back to interleaved through the B-side mirror
    send(2'b00, 8'h15, "R6");
    send(2'b01, 8'h00, "R4");
    send(2'b00, 8'h0A, "R6");
    for (int k = 0; k < 4; k++) send(2'b10, 8'h00, "R2 after switch back");
    check_ports("R4 final");

    bp_on = 1'b0;
    repeat (20) @(negedge clk);
    nvec++;
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL R9: got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule